// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Key-Code FIFO

This block walks a key matrix of up to eight scan lines by eight return lines, one scan line at a time. When a key holds its closure across two visits of its row, the block builds an 8-bit key code and queues it in an eight-entry FIFO. That code holds the row, the column and the levels of the shift and control inputs. A CPU reads the queue and a status byte through a read strobe and a status/data select. An interrupt request stays high while the queue holds any entry. A clear strobe flushes the queue and drops the request.

The scan can be decoded or encoded. In decoded form the block drives one active-low line per row. In encoded form it drives a binary row number for an external decoder to expand. In sensor mode the debounce and the queue are bypassed. A small RAM then holds the latest closure pattern of each row, and the CPU reads it row by row. Mode and clear arrive as already-decoded inputs.

Top module: `keyscan_fifo`

## Requirements
- R1: The matrix size is set by `ROWS` and `COLS` (each 2 to 8). Each row is driven for `DWELL` clock cycles. A return line reads low when the key at the active row and that column is closed.
- R2: With `encoded_i` low, `scan_o` has exactly one bit low, the bit of the row being visited. Rows are visited in ascending order and wrap after `ROWS-1`, each for exactly `DWELL` cycles.
- R3: With `encoded_i` high, `scan_o` carries the row number in binary, zero-extended, so its value is always below `ROWS`.
- R4: A key is accepted only if it reads closed on two consecutive visits of its row. A closure seen on a single visit produces no entry.
- R5: A key held closed produces one entry. Once it is released and pressed again, it produces a new entry.
- R6: A key code is {control, shift, row[2:0], column[2:0]}, from bit 7 down to bit 0. The control and shift levels are those present in the cycle the key is accepted.
- R7: With `sel_stat_i` high, `rdata_o` shows the status byte. Bits 2:0 hold the entry count modulo 8. Bit 3 is full (eight entries), bit 4 is the sticky underrun flag and bit 5 is the sticky overrun flag. Bits 7:6 are zero.
- R8: A one-cycle `rd_i` pulse with `sel_stat_i` low, outside sensor mode, pops the oldest entry. That entry appears on `rdata_o` (with `sel_stat_i` low) from the next cycle, and entries leave in arrival order.
- R9: A key accepted while the FIFO is full is discarded, and the overrun flag is set.
- R10: A data read from an empty FIFO leaves `rdata_o` at the last value read and sets the underrun flag.
- R11: `irq_o` is high exactly when the FIFO holds at least one entry.
- R12: A `clr_i` pulse empties the FIFO, clears both flags, drops `irq_o` and returns the sensor read index to row 0, all by the next cycle.
- R13: With `sensor_i` high, RAM row r bit c is 1 when that key read closed at the last visit of row r. Data reads return RAM rows 0, 1, ... in turn, wrapping after `ROWS-1`. No FIFO entries are made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_i | input | COLS | Return lines, low for a closed key on the active row |
| shift_i | input | 1 | Shift level stored with each key code |
| ctrl_i | input | 1 | Control level stored with each key code |
| encoded_i | input | 1 | 1 selects binary (encoded) scan output |
| sensor_i | input | 1 | 1 selects sensor-RAM mode |
| rd_i | input | 1 | Read strobe, one cycle per read |
| sel_stat_i | input | 1 | 1 shows status on `rdata_o`, 0 shows read data |
| clr_i | input | 1 | Clear strobe |
| scan_o | output | ROWS | Scan lines |
| rdata_o | output | 8 | Status byte or last read data |
| irq_o | output | 1 | Interrupt request, high while the FIFO is not empty |

## Verification
The bench builds the block with a 4×4 matrix and a dwell of 3 cycles, so one full scan takes 12 cycles. With this setting every key position can be swept in both scan forms, each with its own shift and control pattern, in a few thousand cycles. The short scan also puts a sub-scan glitch, a full queue with overrun, an underrun read and a complete sensor-RAM readout with wrap-around within a short run. The expected key codes, status bytes and sensor rows are computed from the row, column and mode of each stimulus.

// File: rtl/keyscan_fifo.sv
module keyscan_fifo #(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int DWELL = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [COLS-1:0] ret_i,
  input  logic            shift_i,
  input  logic            ctrl_i,
  input  logic            encoded_i,
  input  logic            sensor_i,
  input  logic            rd_i,
  input  logic            sel_stat_i,
  input  logic            clr_i,
  output logic [ROWS-1:0] scan_o,
  output logic [7:0]      rdata_o,
  output logic            irq_o
);
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int TW    = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam int DEPTH = 8;

  logic [RW-1:0]   row_q, sidx_q;
  logic [TW-1:0]   tick_q;
  logic [COLS-1:0] prev_q [ROWS];
  logic [COLS-1:0] done_q [ROWS];
  logic [COLS-1:0] sram_q [ROWS];
  logic [7:0]      mem_q  [DEPTH];
  logic [2:0]      wp_q, rp_q;
  logic [3:0]      cnt_q;
  logic            ovr_q, unr_q;
  logic [7:0]      data_q;

  wire             sample  = (tick_q == TW'(DWELL - 1));
  wire [COLS-1:0]  closed  = ~ret_i;
  wire [COLS-1:0]  acc     = closed & prev_q[row_q] & ~done_q[row_q];
  wire             pop_req = rd_i && !sel_stat_i && !sensor_i;
  wire             do_pop  = pop_req && (cnt_q != 4'd0);
  wire             full    = (cnt_q == 4'(DEPTH));

  logic            hit;
  logic [2:0]      col_pick;
  always_comb begin
    hit = 1'b0;
    col_pick = '0;
    for (int c = COLS - 1; c >= 0; c--)
      if (acc[c]) begin
        hit = 1'b1;
        col_pick = 3'(c);
      end
  end

  wire             push    = sample && !sensor_i && hit;
  wire             do_push = push && (!full || do_pop);
  wire [COLS-1:0]  pick    = hit ? (COLS'(1) << col_pick) : '0;
  wire [7:0]       code    = {ctrl_i, shift_i, 3'(row_q), col_pick};

  assign scan_o  = encoded_i ? ROWS'(row_q) : ~(ROWS'(1) << row_q);
  assign irq_o   = (cnt_q != 4'd0);
  assign rdata_o = sel_stat_i ? {2'b00, ovr_q, unr_q, cnt_q[3], cnt_q[2:0]} : data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      row_q  <= '0;
    end else if (sample) begin
      tick_q <= '0;
      row_q  <= (row_q == RW'(ROWS - 1)) ? '0 : row_q + RW'(1);
    end else begin
      tick_q <= tick_q + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        prev_q[r] <= '0;
        done_q[r] <= '0;
        sram_q[r] <= '0;
      end
    end else if (sample) begin
      if (sensor_i) begin
        sram_q[row_q] <= closed;
      end else begin
        prev_q[row_q] <= closed;
        done_q[row_q] <= (done_q[row_q] | (push ? pick : '0)) & closed;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
      unr_q  <= 1'b0;
      sidx_q <= '0;
      if (!rst_n) data_q <= '0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= code;
        wp_q <= wp_q + 3'd1;
      end
      if (push && full && !do_pop) ovr_q <= 1'b1;
      if (do_pop) begin
        data_q <= mem_q[rp_q];
        rp_q   <= rp_q + 3'd1;
      end
      if (pop_req && cnt_q == 4'd0) unr_q <= 1'b1;
      if (do_push && !do_pop) cnt_q <= cnt_q + 4'd1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 4'd1;
      if (rd_i && !sel_stat_i && sensor_i) begin
        data_q <= 8'(sram_q[sidx_q]);
        sidx_q <= (sidx_q == RW'(ROWS - 1)) ? '0 : sidx_q + RW'(1);
      end
    end
  end

  assert_scan_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !encoded_i |-> $countones(scan_o) == ROWS - 1);
  assert_encoded_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    encoded_i |-> scan_o < ROWS'(ROWS));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 4'(DEPTH));
  assert_full_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr_i && !pop_req) |=> full);
  assert_underrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt_q == 4'd0 && !clr_i) |=> (unr_q && $stable(data_q)));
  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == 4'd0 && !irq_o && !ovr_q && !unr_q));
  assert_sensor_nopush_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (sensor_i && !clr_i) |=> cnt_q <= $past(cnt_q));
endmodule

// File: tb/keyscan_fifo_tb.sv
`timescale 1ns/1ps
module keyscan_fifo_tb_top;
  localparam int NR = 4, NC = 4, DW = 3, SCAN = NR * DW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] ret_i;
  logic shift_i = 0, ctrl_i = 0, encoded_i = 0, sensor_i = 0;
  logic rd_i = 0, sel_stat_i = 0, clr_i = 0;
  logic [NR-1:0] scan_o;
  logic [7:0] rdata_o;
  logic irq_o;
  logic [NC-1:0] key_q [NR];
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  keyscan_fifo #(.ROWS(NR), .COLS(NC), .DWELL(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ret_i(ret_i), .shift_i(shift_i), .ctrl_i(ctrl_i),
    .encoded_i(encoded_i), .sensor_i(sensor_i), .rd_i(rd_i), .sel_stat_i(sel_stat_i),
    .clr_i(clr_i), .scan_o(scan_o), .rdata_o(rdata_o), .irq_o(irq_o));

  always_comb begin
    ret_i = '1;
    for (int r = 0; r < NR; r++)
      if (encoded_i ? (scan_o == NR'(r)) : !scan_o[r]) ret_i = ret_i & ~key_q[r];
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic status(output int s);
    sel_stat_i = 1'b1;
    #1 s = int'(rdata_o);
    sel_stat_i = 1'b0;
  endtask

  task automatic read_data(output int d);
    @(negedge clk) rd_i = 1'b1; sel_stat_i = 1'b0;
    @(negedge clk) rd_i = 1'b0;
    #1 d = int'(rdata_o);
  endtask

  task automatic tap(int r, int c, int hold);
    key_q[r][c] = 1'b1;
    wait_cyc(hold);
    key_q[r][c] = 1'b0;
    wait_cyc(2 * SCAN);
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr_i = 1'b1;
    @(negedge clk) clr_i = 1'b0;
  endtask

  function automatic int kcode(int ctl, int sh, int r, int c);
    return (ctl << 7) | (sh << 6) | (r << 3) | c;
  endfunction

  initial begin
    #(100000 * 5);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s, d, err, prev, run, seen;
    for (int r = 0; r < NR; r++) key_q[r] = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    #1;
    status(s); check("R7 reset status", s, 0);
    check("R11 reset irq", int'(irq_o), 0);
    check("R2 reset scan row0", int'(scan_o), 4'b1110);

    err = 0; prev = -1; run = 0; seen = 0;
    for (int i = 0; i < 3 * SCAN; i++) begin
      int idx, zeros;
      @(negedge clk);
      idx = 0; zeros = 0;
      for (int r = 0; r < NR; r++) if (!scan_o[r]) begin zeros++; idx = r; end
      if (zeros != 1) err++;
      if (idx == prev) run++;
      else begin
        if (prev >= 0 && idx != (prev + 1) % NR) err++;
        if (seen && run != DW) err++;
        if (prev >= 0) seen = 1;
        prev = idx; run = 1;
      end
    end
    check("R2 decoded scan order and dwell", err, 0);

    encoded_i = 1'b1;
    err = 0; prev = -1; run = 0; seen = 0;
    for (int i = 0; i < 3 * SCAN; i++) begin
      @(negedge clk);
      if (int'(scan_o) >= NR) err++;
      if (int'(scan_o) == prev) run++;
      else begin
        if (prev >= 0 && int'(scan_o) != (prev + 1) % NR) err++;
        if (seen && run != DW) err++;
        if (prev >= 0) seen = 1;
        prev = int'(scan_o); run = 1;
      end
    end
    check("R3 encoded scan values", err, 0);

    for (int m = 0; m < 2; m++) begin
      encoded_i = (m == 1);
      for (int r = 0; r < NR; r++)
        for (int c = 0; c < NC; c++) begin
          shift_i = r[0] ^ m[0]; ctrl_i = c[0];
          tap(r, c, 3 * SCAN);
          status(s); check("R5 one entry per held key", s, 1);
          check("R11 irq with data", int'(irq_o), 1);
          read_data(d);
          check("R6 key code", d, kcode(c & 1, (r & 1) ^ m, r, c));
          status(s); check("R8 status after pop", s, 0);
          check("R11 irq empty", int'(irq_o), 0);
        end
    end
    encoded_i = 1'b0; shift_i = 0; ctrl_i = 0;

    for (int k = 0; k < 4; k++) begin
      tap(k, (k + 1) % NC, SCAN - 2);
      status(s); check("R4 sub-scan glitch ignored", s, 0);
    end

    tap(2, 1, 3 * SCAN);
    tap(2, 1, 3 * SCAN);
    status(s); check("R5 re-press gives new entry", s, 2);
    pulse_clr();
    status(s); check("R12 clear empties", s, 0);
    check("R12 clear drops irq", int'(irq_o), 0);

    for (int k = 0; k < 9; k++) tap(k / NC, k % NC, 3 * SCAN);
    status(s); check("R9 full with overrun", s, 8'h28);
    for (int k = 0; k < 8; k++) begin
      read_data(d);
      check("R8 FIFO order", d, kcode(0, 0, k / NC, k % NC));
    end
    status(s); check("R9 overrun sticky", s, 8'h20);
    read_data(d);
    check("R10 underrun keeps data", d, kcode(0, 0, 1, 3));
    status(s); check("R10 underrun flag", s, 8'h30);
    pulse_clr();
    status(s); check("R12 clear flags", s, 0);

    sensor_i = 1'b1;
    for (int r = 0; r < NR; r++) key_q[r] = NC'((r * 7 + 3) & 15);
    wait_cyc(3 * SCAN);
    status(s); check("R13 sensor no FIFO entries", s, 0);
    pulse_clr();
    for (int r = 0; r <= NR; r++) begin
      read_data(d);
      check("R13 sensor row", d, ((r % NR) * 7 + 3) & 15);
    end
    check("R13 sensor irq low", int'(irq_o), 0);
    for (int r = 0; r < NR; r++) key_q[r] = '0;
    wait_cyc(2 * SCAN);
    sensor_i = 1'b0;
    wait_cyc(2 * SCAN);
    status(s); check("R13 leave sensor clean", s, 0);
    check("R1 matrix idle irq", int'(irq_o), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule